// File: doc/BRIEF.md
# Watchdog Timer with Seconds/Minutes Unit and Level or Pulse Reset

The block is a countdown watchdog controlled through byte-wide indexed register writes and reads. Software loads an 8-bit count and chooses whether one count step lasts one second or one minute of timebase strobes. Every write of the count register reloads the counter, and this write is the keepalive. When the count runs out, the block sets a sticky expiry flag and pulls its active-low reset pin low. The reset is either a level that holds until the next reload or a disable, or a single pulse whose length is chosen by a 2-bit code.

The timer counts only while two bits are set: the watchdog enable in the configuration register and a separate unit enable. A third register holds an output-enable bit that gates the reset pin. The `tick_i` strobe (nominally 1 ms) supplies the timebase. Parameters set the number of strobes per second, the seconds per minute, and the four pulse widths in strobes.

Register indices: unit enable 0x30 (bit 0), output enable 0xF0 (bit 7), configuration 0xF5, count 0xF6. Configuration bits: 6 expiry status (write 1 to clear), 5 enable, 4 pulse mode (1) or level mode (0), 3 minutes (1) or seconds (0), 1:0 pulse-width code.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the reset pin is high, and indices 0x30, 0xF0, 0xF5 and 0xF6 all read 0.
- R2: The count and its prescaler hold their value unless config bit 5 and unit-enable bit 0 are both 1.
- R3: In seconds mode (bit 3 = 0) a loaded count N of 1 or more expires after exactly N*TICKS_PER_SEC strobes. A count of 0 expires after one unit.
- R4: In minutes mode (bit 3 = 1) a count N of 1 or more expires after N*TICKS_PER_SEC*SEC_PER_MIN strobes.
- R5: A write to index 0xF6 loads the count, restarts the prescaler, ends any expiry or pulse, and takes effect on the next cycle. Reads of 0xF6 return the live count. The count never increases except through this write.
- R6: Config bit 6 sets on expiry and stays set. A config write with bit 6 = 1 clears it, and a write with bit 6 = 0 leaves it alone. An expiry in the same cycle as a clear leaves the bit set.
- R7: In level mode (bit 4 = 0) the pin stays low after expiry, for any number of further strobes, until a reload or a disable.
- R8: In pulse mode (bit 4 = 1) the pin goes low once at expiry, for PW0, PW1, PW2 or PW3 strobes for codes 0, 1, 2 or 3 in bits 1:0. The pin then stays high.
- R9: With bit 7 of index 0xF0 at 0 the pin stays high even though the status bit sets on expiry. Setting the bit drives a pending level reset out at once.
- R10: Clearing config bit 5 freezes the count and releases the pin. Setting the bit again resumes counting from where it stopped.
- R11: Writable fields read back in place. Bits without a field and indices without a register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| wr_i | input | 1 | Register write strobe |
| idx_i | input | 8 | Register index for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `idx_i`, combinational |
| wdt_rst_no | output | 1 | Watchdog reset output, active low |

## Verification
The checker tests on every cycle that:
- the count holds while the timer is stopped and never rises except by a reload;
- a reload lands the written value and releases the pin;
- the status bit survives every cycle without a write-1 clear;
- the pin is high whenever the enable is clear.

Only the bench scenarios can show the exact strobe counts to expiry in both units, the four pulse lengths, the frozen-then-resumed count, and the same-cycle set-versus-clear of the status flag.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] IDX_DEVEN = 8'h30;
  localparam logic [7:0] IDX_OUTEN = 8'hF0;
  localparam logic [7:0] IDX_CFG   = 8'hF5;
  localparam logic [7:0] IDX_TIME  = 8'hF6;

  localparam int unsigned B_STATUS = 6;
  localparam int unsigned B_EN     = 5;
  localparam int unsigned B_PULSE  = 4;
  localparam int unsigned B_MINUTE = 3;
  localparam int unsigned B_OUTEN  = 7;

  typedef struct packed {
    logic       en;
    logic       pulse;
    logic       minutes;
    logic [1:0] pw_code;
  } cfg_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] count_i,
  input  logic       expire_i,
  output logic [7:0] rdata_o,
  output cfg_t       cfg_o,
  output logic       dev_en_o,
  output logic       out_en_o,
  output logic       status_o,
  output logic       reload_o
);
  logic wr_cfg, wr_oen, wr_den, stat_clr;

  assign wr_cfg   = wr_i && (idx_i == IDX_CFG);
  assign wr_oen   = wr_i && (idx_i == IDX_OUTEN);
  assign wr_den   = wr_i && (idx_i == IDX_DEVEN);
  assign reload_o = wr_i && (idx_i == IDX_TIME);
  assign stat_clr = wr_cfg && wdata_i[B_STATUS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      dev_en_o <= 1'b0;
      out_en_o <= 1'b0;
      status_o <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_o.en      <= wdata_i[B_EN];
        cfg_o.pulse   <= wdata_i[B_PULSE];
        cfg_o.minutes <= wdata_i[B_MINUTE];
        cfg_o.pw_code <= wdata_i[1:0];
      end
      if (wr_oen) out_en_o <= wdata_i[B_OUTEN];
      if (wr_den) dev_en_o <= wdata_i[0];
      // set beats a same-cycle clear
      if (expire_i)      status_o <= 1'b1;
      else if (stat_clr) status_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_DEVEN: rdata_o[0] = dev_en_o;
      IDX_OUTEN: rdata_o[B_OUTEN] = out_en_o;
      IDX_CFG: begin
        rdata_o[B_STATUS] = status_o;
        rdata_o[B_EN]     = cfg_o.en;
        rdata_o[B_PULSE]  = cfg_o.pulse;
        rdata_o[B_MINUTE] = cfg_o.minutes;
        rdata_o[1:0]      = cfg_o.pw_code;
      end
      IDX_TIME: rdata_o = count_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_ok_i,
  input  logic       minutes_i,
  input  logic       reload_i,
  input  logic [7:0] load_i,
  output logic [7:0] count_o,
  output logic       expire_o,
  output logic       expired_o
);
  localparam int unsigned MIN_TICKS = TICKS_PER_SEC * SEC_PER_MIN;
  localparam int unsigned PRE_W     = $clog2(MIN_TICKS + 1);

  logic [PRE_W-1:0] pre_q, lim;
  logic             counting, unit_edge;

  assign lim       = minutes_i ? PRE_W'(MIN_TICKS - 1) : PRE_W'(TICKS_PER_SEC - 1);
  assign counting  = run_ok_i && !expired_o && tick_i && !reload_i;
  // >= covers a unit switch to seconds in mid-minute
  assign unit_edge = counting && (pre_q >= lim);
  assign expire_o  = unit_edge && (count_o <= 8'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      count_o   <= '0;
      expired_o <= 1'b0;
    end else if (reload_i) begin
      pre_q     <= '0;
      count_o   <= load_i;
      expired_o <= 1'b0;
    end else if (!run_ok_i) begin
      expired_o <= 1'b0;
    end else if (counting) begin
      if (unit_edge) begin
        pre_q <= '0;
        if (count_o <= 8'd1) begin
          count_o   <= '0;
          expired_o <= 1'b1;
        end else begin
          count_o <= count_o - 8'd1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_rstgen.sv
module wdg_rstgen #(
  parameter int unsigned PW0 = 1,
  parameter int unsigned PW1 = 25,
  parameter int unsigned PW2 = 125,
  parameter int unsigned PW3 = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       expire_i,
  input  logic       cancel_i,
  input  logic       pulse_mode_i,
  input  logic [1:0] pw_code_i,
  input  logic       expired_i,
  input  logic       run_ok_i,
  input  logic       out_en_i,
  output logic       rst_no
);
  localparam int unsigned M01    = (PW0 > PW1) ? PW0 : PW1;
  localparam int unsigned M23    = (PW2 > PW3) ? PW2 : PW3;
  localparam int unsigned PW_MAX = (M01 > M23) ? M01 : M23;
  localparam int unsigned PCW    = $clog2(PW_MAX + 1);

  logic [PCW-1:0] width, left_q;
  logic           act_q, assert_rst;

  always_comb begin
    unique case (pw_code_i)
      2'd0: width = PCW'(PW0);
      2'd1: width = PCW'(PW1);
      2'd2: width = PCW'(PW2);
      default: width = PCW'(PW3);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      left_q <= '0;
    end else if (cancel_i) begin
      act_q <= 1'b0;
    end else if (expire_i && pulse_mode_i) begin
      act_q  <= 1'b1;
      left_q <= width;
    end else if (act_q && tick_i) begin
      if (left_q <= PCW'(1)) act_q <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end

  assign assert_rst = out_en_i && run_ok_i && (pulse_mode_i ? act_q : expired_i);
  assign rst_no     = ~assert_rst;
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned PW0           = 1,
  parameter int unsigned PW1           = 25,
  parameter int unsigned PW2           = 125,
  parameter int unsigned PW3           = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wdt_rst_no
);
  cfg_t       cfg;
  logic       dev_en, out_en, status, reload, run_ok, expire, expired;
  logic [7:0] count;

  assign run_ok = cfg.en && dev_en;

  wdg_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .idx_i, .wdata_i,
    .count_i(count), .expire_i(expire), .rdata_o,
    .cfg_o(cfg), .dev_en_o(dev_en), .out_en_o(out_en),
    .status_o(status), .reload_o(reload)
  );

  wdg_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_timer (
    .clk_i, .rst_ni, .tick_i, .run_ok_i(run_ok), .minutes_i(cfg.minutes),
    .reload_i(reload), .load_i(wdata_i), .count_o(count),
    .expire_o(expire), .expired_o(expired)
  );

  wdg_rstgen #(.PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)) u_rst (
    .clk_i, .rst_ni, .tick_i, .expire_i(expire),
    .cancel_i(reload || !run_ok), .pulse_mode_i(cfg.pulse),
    .pw_code_i(cfg.pw_code), .expired_i(expired), .run_ok_i(run_ok),
    .out_en_i(out_en), .rst_no(wdt_rst_no)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [7:0] idx_i,
  input logic [7:0] wdata_i,
  input logic [7:0] count,
  input logic       run_ok,
  input logic       reload,
  input logic       status,
  input logic       en,
  input logic       wdt_rst_no
);
  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_ok && !reload) |=> $stable(count));

  assert_no_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload |=> (count <= $past(count)));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (count == $past(wdata_i)) && wdt_rst_no);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status && !(wr_i && idx_i == IDX_CFG && wdata_i[B_STATUS])) |=> status);

  assert_off_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> wdt_rst_no);
endmodule

bind tick_watchdog wdg_checker u_chk (
  .clk_i, .rst_ni, .wr_i, .idx_i, .wdata_i, .count, .run_ok, .reload,
  .status, .en(cfg.en), .wdt_rst_no
);

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  localparam int unsigned TPS = 4;
  localparam int unsigned SPM = 3;
  localparam int unsigned PWS [4] = '{1, 2, 3, 5};
  // {count, minutes, strobes to expiry}
  localparam logic [7:0] VEC [6][3] = '{
    '{8'd3, 8'd0, 8'd12}, '{8'd0, 8'd0, 8'd4}, '{8'd1, 8'd0, 8'd4},
    '{8'd2, 8'd1, 8'd24}, '{8'd1, 8'd1, 8'd12}, '{8'd10, 8'd0, 8'd40}};

  logic clk = 0, rst_n = 0, tick = 0, wr = 0;
  logic [7:0] idx = 0, wdata = 0, rdata, rd_v;
  logic rst_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  tick_watchdog #(.TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM),
    .PW0(PWS[0]), .PW1(PWS[1]), .PW2(PWS[2]), .PW3(PWS[3])) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .idx_i(idx),
    .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_no(rst_o));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] i, logic [7:0] d);
    @(negedge clk); wr = 1; idx = i; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [7:0] i);
    idx = i; #1 rd_v = rdata;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 pin", rst_o, 1);
    rd_reg(8'h30); check("R1 r30", rd_v, 0);
    rd_reg(8'hF0); check("R1 rF0", rd_v, 0);
    rd_reg(8'hF5); check("R1 rF5", rd_v, 0);
    rd_reg(8'hF6); check("R1 rF6", rd_v, 0);

    // R11
    wr_reg(8'h55, 8'hFF); rd_reg(8'h55); check("R11 unmapped", rd_v, 0);
    wr_reg(8'hF5, 8'hFF); rd_reg(8'hF5); check("R11 cfg", rd_v, 8'h3B);
    wr_reg(8'hF0, 8'hFF); rd_reg(8'hF0); check("R11 outen", rd_v, 8'h80);
    wr_reg(8'h30, 8'hFF); rd_reg(8'h30); check("R11 deven", rd_v, 8'h01);

    // R3/R4 vector table, level mode
    for (int v = 0; v < 6; v++) begin
      wr_reg(8'hF5, 8'h60 | (VEC[v][1] << 3));
      wr_reg(8'hF6, VEC[v][0]);
      ticks(VEC[v][2] - 1);
      check(VEC[v][1] ? "R4 before" : "R3 before", rst_o, 1);
      ticks(1);
      check(VEC[v][1] ? "R4 expiry" : "R3 expiry", rst_o, 0);
      rd_reg(8'hF5); check("R6 status set", rd_v[6], 1);
    end

    // R7 level holds, ends on reload
    ticks(30); check("R7 held", rst_o, 0);
    wr_reg(8'hF6, 8'd1); check("R7 reload ends", rst_o, 1);
    ticks(4); check("R7 re-expiry", rst_o, 0);
    wr_reg(8'hF5, 8'h08); check("R10 disable ends", rst_o, 1);

    // R6 sticky, write 0 keeps, write 1 clears
    wr_reg(8'hF5, 8'h20); rd_reg(8'hF5); check("R6 keep", rd_v, 8'h60);
    wr_reg(8'hF5, 8'h60); rd_reg(8'hF5); check("R6 clear", rd_v, 8'h20);
    // R6 set wins over same-cycle clear
    wr_reg(8'hF6, 8'd1); ticks(3);
    @(negedge clk); tick = 1; wr = 1; idx = 8'hF5; wdata = 8'h60;
    @(negedge clk); tick = 0; wr = 0;
    rd_reg(8'hF5); check("R6 set wins", rd_v, 8'h60);

    // R2 gating by each enable
    wr_reg(8'h30, 8'h00); wr_reg(8'hF6, 8'd5); ticks(20);
    rd_reg(8'hF6); check("R2 unit off count", rd_v, 5); check("R2 unit off pin", rst_o, 1);
    wr_reg(8'h30, 8'h01); wr_reg(8'hF5, 8'h00); ticks(20);
    rd_reg(8'hF6); check("R2 en off count", rd_v, 5);

    // R5 keepalive
    wr_reg(8'hF5, 8'h60); wr_reg(8'hF6, 8'd2); ticks(7);
    wr_reg(8'hF6, 8'd2); ticks(7);
    check("R5 keepalive pin", rst_o, 1);
    rd_reg(8'hF6); check("R5 live count", rd_v, 1);
    ticks(1); check("R5 expiry after reload", rst_o, 0);

    // R10 freeze and resume
    wr_reg(8'hF6, 8'd3); ticks(5);
    wr_reg(8'hF5, 8'h40); ticks(10);
    rd_reg(8'hF6); check("R10 frozen", rd_v, 2);
    wr_reg(8'hF5, 8'h20); ticks(6); check("R10 resume before", rst_o, 1);
    ticks(1); check("R10 resume expiry", rst_o, 0);

    // R9 output gate
    wr_reg(8'hF0, 8'h00); wr_reg(8'hF5, 8'h60); wr_reg(8'hF6, 8'd1); ticks(4);
    check("R9 gated pin", rst_o, 1);
    rd_reg(8'hF5); check("R9 status", rd_v, 8'h60);
    wr_reg(8'hF0, 8'h80); check("R9 ungated", rst_o, 0);

    // R8 pulse widths
    for (int c = 0; c < 4; c++) begin
      wr_reg(8'hF5, 8'h70 | c);
      wr_reg(8'hF6, 8'd1); ticks(4);
      check("R8 pulse start", rst_o, 0);
      if (PWS[c] > 1) begin
        ticks(PWS[c] - 1); check("R8 pulse held", rst_o, 0);
      end
      ticks(1); check("R8 pulse end", rst_o, 1);
      ticks(10); check("R8 once", rst_o, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule